// File: doc/BRIEF.md
# Elastic Audio Sample Buffer with Local Clock Trim

This block decouples an incoming audio stream from the local playback clock. Samples arrive with a write strobe in the source clock domain. They are stored in a small dual-clock buffer of 44 entries, which is about 1 ms of audio at 44.1 kHz. The local clock drains the buffer once per sample tick. Playback stays silent after reset until the buffer is half full, so the buffer has equal headroom for drift in both directions.

The same local clock counts rising edges of the incoming bit clock during fixed gate windows. The per-gate count errors are summed over a long averaging window, so short-term jitter cancels out. The block asks an external programmable oscillator to run faster or slower only when that averaged error is large enough. It also asks when the fill level leaves a guard band around the midpoint. Requests are rare and discrete: a one-cycle pulse, plus a direction and a signed step that stay put until the oscillator side acknowledges.

Top module: `elastic_trim_fifo`

## Requirements
- R1: After reset the buffer is empty and playback is off. The playback sample, both sticky flags and the trim request are 0.
- R2: Playback does not start, and read ticks neither pop data nor change the output, until the fill level reaches DEPTH/2 (22). Once started, playback stays on.
- R3: Samples leave the buffer in the order they were written, with the data unchanged. The reported fill level equals writes accepted minus reads, and it never exceeds DEPTH.
- R4: A write that arrives while the buffer holds DEPTH samples is dropped, and it sets a sticky overflow flag. Only the overflow clear input, sampled on the write clock, clears that flag.
- R5: A read tick while playing with an empty buffer repeats the last sample and sets a sticky underflow flag. Only the underflow clear input clears that flag.
- R6: Incoming bit-clock rising edges are counted in gates of GATE_CYC local cycles. Each gate's count minus EXPECT is summed over 2^AVG_LOG2 gates. At the end of that window, a sum whose magnitude is at least THRESH raises a request. Direction is faster (1) when the sum is positive. The step is the sum arithmetically shifted right by AVG_LOG2, saturated to the step width.
- R7: A bit-clock rate whose averaged error stays below THRESH produces no request.
- R8: While playing, a fill level above DEPTH/2+GUARD forces a faster request with step +1. A fill level below DEPTH/2-GUARD forces a slower request with step -1. The guard takes priority over the averaged error in the same cycle.
- R9: Each request clears the accumulator and restarts the window. No further request can issue until a full window has elapsed, and no guard request can issue before the first window after reset ends.
- R10: The request is a one-cycle pulse. Direction and step stay stable, and no new request issues, until the acknowledge input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_clk | input | 1 | Source-domain clock |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | DW | Stereo sample to store |
| ovf_clr | input | 1 | Clears the overflow flag (write clock) |
| bclk_in | input | 1 | Incoming bit clock being measured |
| loc_clk | input | 1 | Local playback and reference clock |
| rd_en | input | 1 | Playback sample tick |
| udf_clr | input | 1 | Clears the underflow flag (local clock) |
| trim_ack | input | 1 | Oscillator side has taken the request |
| rd_data | output | DW | Playback sample |
| fill | output | $clog2(DEPTH)+1 | Fill level seen in the local domain |
| playing | output | 1 | Playback running |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |
| trim_req | output | 1 | One-cycle trim request pulse |
| trim_faster | output | 1 | 1: local clock must speed up |
| trim_step | output | STEPW | Signed trim step |

## Verification
The averaged-rate decision and the fill guard can both fire at the same window end. In that case they may disagree on direction. The bench provokes this case by filling the buffer above the guard band while the bit clock runs slow. The guard cannot act before the first window completes, so both triggers land on the same edge. The result is correct only if that single request says faster with step +1, rather than slower with the averaged step. A second guard request below the band, after the acknowledge, must then carry step -1.

// File: rtl/elastic_trim_fifo.sv
module elastic_trim_fifo #(
  parameter int DEPTH    = 44,
  parameter int DW       = 48,
  parameter int GATE_CYC = 4096,
  parameter int AVG_LOG2 = 6,
  parameter int EXPECT   = 1024,
  parameter int THRESH   = 64,
  parameter int GUARD    = 16,
  parameter int STEPW    = 8
) (
  input  logic                    rst_n,
  input  logic                    wr_clk,
  input  logic                    wr_en,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ovf_clr,
  input  logic                    bclk_in,
  input  logic                    loc_clk,
  input  logic                    rd_en,
  input  logic                    udf_clr,
  input  logic                    trim_ack,
  output logic [DW-1:0]           rd_data,
  output logic [$clog2(DEPTH):0]  fill,
  output logic                    playing,
  output logic                    ovf_flag,
  output logic                    udf_flag,
  output logic                    trim_req,
  output logic                    trim_faster,
  output logic signed [STEPW-1:0] trim_step
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int MID = DEPTH / 2;
  localparam int GW  = $clog2(GATE_CYC);
  localparam int CW  = GW + 1;
  localparam int WW  = AVG_LOG2 + 1;
  localparam int ACW = CW + AVG_LOG2 + 2;
  localparam logic signed [ACW-1:0] SMAX = ACW'(2**(STEPW-1) - 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [2**AW];
  logic [PW-1:0] wbin, wgray, rg1, rg2, rbin, rgray, wg1, wg2;

  wire [PW-1:0] wnext = wbin + 1'b1;
  wire [PW-1:0] rnext = rbin + 1'b1;
  wire [PW-1:0] wfill = wbin - g2b(rg2);
  wire          wfull = wfill >= PW'(DEPTH);
  assign fill = g2b(wg2) - rbin;

  always_ff @(posedge wr_clk) if (wr_en && !wfull) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0; ovf_flag <= 1'b0;
    end else begin
      rg1 <= rgray; rg2 <= rg1;
      if (ovf_clr) ovf_flag <= 1'b0;
      if (wr_en) begin
        if (wfull) ovf_flag <= 1'b1;
        else begin
          wbin  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end
    end

  always_ff @(posedge loc_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0;
      playing <= 1'b0; rd_data <= '0; udf_flag <= 1'b0;
    end else begin
      wg1 <= wgray; wg2 <= wg1;
      if (udf_clr) udf_flag <= 1'b0;
      if (!playing) begin
        if (fill >= PW'(MID)) playing <= 1'b1;
      end else if (rd_en) begin
        if (fill != '0) begin
          rd_data <= mem[rbin[AW-1:0]];
          rbin    <= rnext;
          rgray   <= rnext ^ (rnext >> 1);
        end else udf_flag <= 1'b1;
      end
    end

  logic [2:0]                bs;
  logic [GW-1:0]             gate_cnt;
  logic [CW-1:0]             ecnt;
  logic [WW-1:0]             win_cnt;
  logic signed [ACW-1:0]     acc, gerr, acc_n, avg;
  logic [ACW-1:0]            mag;
  logic signed [STEPW-1:0]   step_sat;
  logic                      pend, armed;

  wire bedge    = bs[1] & ~bs[2];
  wire gate_end = gate_cnt == GW'(GATE_CYC - 1);
  wire win_end  = gate_end && (win_cnt == WW'((1 << AVG_LOG2) - 1));
  assign gerr   = ACW'(ecnt) + ACW'(bedge) - ACW'(EXPECT);
  assign acc_n  = acc + gerr;
  assign avg    = acc_n >>> AVG_LOG2;
  assign mag    = acc_n[ACW-1] ? ACW'(-acc_n) : ACW'(acc_n);
  assign step_sat = (avg > SMAX) ? STEPW'(SMAX) : (avg < -SMAX) ? STEPW'(-SMAX) : avg[STEPW-1:0];

  wire thr_hit = win_end && (mag >= ACW'(THRESH));
  wire hi      = playing && (fill > PW'(MID + GUARD));
  wire lo      = playing && (MID > GUARD) && (fill < PW'(MID - GUARD));
  wire fire    = !pend && (armed || win_end) && (hi || lo || thr_hit);

  always_ff @(posedge loc_clk or negedge rst_n)
    if (!rst_n) begin
      bs <= '0; gate_cnt <= '0; ecnt <= '0; win_cnt <= '0; acc <= '0;
      pend <= 1'b0; armed <= 1'b0;
      trim_req <= 1'b0; trim_faster <= 1'b0; trim_step <= '0;
    end else begin
      bs <= {bs[1:0], bclk_in};
      trim_req <= 1'b0;
      if (trim_ack) pend <= 1'b0;
      gate_cnt <= gate_end ? '0 : gate_cnt + 1'b1;
      ecnt     <= gate_end ? '0 : ecnt + CW'(bedge);
      if (gate_end) begin
        win_cnt <= win_end ? '0 : win_cnt + 1'b1;
        acc     <= win_end ? '0 : acc_n;
      end
      if (win_end) armed <= 1'b1;
      if (fire) begin
        trim_req    <= 1'b1;
        pend        <= 1'b1;
        armed       <= 1'b0;
        gate_cnt    <= '0;
        ecnt        <= '0;
        win_cnt     <= '0;
        acc         <= '0;
        trim_faster <= hi ? 1'b1 : lo ? 1'b0 : !acc_n[ACW-1];
        trim_step   <= hi ? STEPW'(1) : lo ? '1 : step_sat;
      end
    end

  // R3
  fill_bound_chk: assert property (@(posedge loc_clk) disable iff (!rst_n) fill <= PW'(DEPTH));
  // R2
  start_level_chk: assert property (@(posedge loc_clk) disable iff (!rst_n)
    $rose(playing) |-> $past(fill) >= PW'(MID));
  // R4
  ovf_set_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en && wfull |=> ovf_flag && $stable(wbin));
  // R5
  udf_repeat_chk: assert property (@(posedge loc_clk) disable iff (!rst_n)
    playing && rd_en && fill == '0 && !udf_clr |=> udf_flag && $stable(rd_data));
  // R10
  req_pulse_chk: assert property (@(posedge loc_clk) disable iff (!rst_n) trim_req |=> !trim_req);
  // R10
  req_hold_chk: assert property (@(posedge loc_clk) disable iff (!rst_n)
    pend && !trim_ack |=> $stable(trim_step) && $stable(trim_faster) && !trim_req);
  // R8
  guard_dir_chk: assert property (@(posedge loc_clk) disable iff (!rst_n)
    !pend && hi && (armed || win_end) |=> trim_req && trim_faster && trim_step == STEPW'(1));
endmodule

// File: tb/elastic_trim_fifo_tb.sv
module elastic_trim_fifo_tb;
  localparam int DW = 16;
  logic rst_n = 0, wr_clk = 0, loc_clk = 0, wr_en = 0, ovf_clr = 0, rd_en = 0, udf_clr = 0, trim_ack = 0;
  logic bclk;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [6:0] fill;
  logic playing, ovf_flag, udf_flag, trim_req, trim_faster;
  logic signed [7:0] trim_step;

  elastic_trim_fifo #(.DEPTH(44), .DW(DW), .GATE_CYC(64), .AVG_LOG2(2), .EXPECT(16),
    .THRESH(8), .GUARD(16), .STEPW(8)) u_dut (
    .rst_n, .wr_clk, .wr_en, .wr_data, .ovf_clr, .bclk_in(bclk), .loc_clk, .rd_en,
    .udf_clr, .trim_ack, .rd_data, .fill, .playing, .ovf_flag, .udf_flag,
    .trim_req, .trim_faster, .trim_step);

  always #4 loc_clk = ~loc_clk;
  always #5 wr_clk = ~wr_clk;

  int vectors = 0, fails = 0, bper = 4, bcnt = 0, ncyc = 0, req_n = 0;
  int rq_t[4], rq_s[4], rq_f[4];
  bit auto_ack = 1, done = 0;
  assign bclk = (bcnt == 0);

  always @(negedge loc_clk) begin
    bcnt = (bcnt >= bper - 1) ? 0 : bcnt + 1;
    ncyc++;
    if (rst_n && trim_req) begin
      if (req_n < 4) begin rq_t[req_n] = ncyc; rq_s[req_n] = int'(trim_step); rq_f[req_n] = int'(trim_faster); end
      req_n++;
    end
    trim_ack = auto_ack && trim_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic do_reset(input int per, input bit ack);
    rst_n = 0; wr_en = 0; rd_en = 0; bper = per; auto_ack = ack;
    repeat (3) @(negedge loc_clk);
    req_n = 0; ncyc = 0;
    rst_n = 1;
  endtask

  task automatic wr1(input int d);
    @(negedge wr_clk) begin wr_en = 1; wr_data = DW'(d); end
    @(negedge wr_clk) wr_en = 0;
  endtask

  task automatic rd1;
    @(negedge loc_clk) rd_en = 1;
    @(negedge loc_clk) rd_en = 0;
  endtask

  task automatic settle;
    repeat (6) @(negedge loc_clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // Phase A: buffer behaviour
    do_reset(4, 1);
    settle;
    chk(fill == 0 && !playing, "R1 fill/playing", int'(fill), 0);
    chk(rd_data == 0 && !ovf_flag && !udf_flag && !trim_req, "R1 outputs", int'(rd_data), 0);
    for (int i = 0; i < 10; i++) wr1(100 + i);
    settle;
    chk(fill == 10 && !playing, "R2 below half", int'(fill), 10);
    repeat (3) rd1;
    settle;
    chk(fill == 10 && rd_data == 0, "R2 reads ignored", int'(rd_data), 0);
    for (int i = 10; i < 22; i++) wr1(100 + i);
    settle;
    chk(playing == 1, "R2 start at half", int'(playing), 1);
    for (int i = 0; i < 22; i++) begin
      rd1;
      chk(rd_data == DW'(100 + i), "R3 order", int'(rd_data), 100 + i);
    end
    settle;
    chk(fill == 0, "R3 drained", int'(fill), 0);
    rd1;
    settle;
    chk(rd_data == DW'(121) && udf_flag, "R5 repeat last", int'(rd_data), 121);
    @(negedge loc_clk) udf_clr = 1;
    @(negedge loc_clk) udf_clr = 0;
    settle;
    chk(!udf_flag, "R5 clear", int'(udf_flag), 0);
    for (int k = 1; k <= 50; k++) begin
      wr1(200 + k - 1);
      settle;
      chk(int'(fill) == ((k > 44) ? 44 : k), "R3 fill sweep", int'(fill), (k > 44) ? 44 : k);
      chk(ovf_flag == (k > 44), "R4 overflow flag", int'(ovf_flag), int'(k > 44));
    end
    for (int i = 0; i < 44; i++) begin
      rd1;
      chk(rd_data == DW'(200 + i), "R4 dropped tail", int'(rd_data), 200 + i);
    end
    @(negedge wr_clk) ovf_clr = 1;
    @(negedge wr_clk) ovf_clr = 0;
    settle;
    chk(!ovf_flag, "R4 clear", int'(ovf_flag), 0);

    // Phase B: averaged rate decisions
    do_reset(4, 1);
    repeat (700) @(negedge loc_clk);
    chk(req_n == 0, "R7 nominal rate no trim", req_n, 0);

    do_reset(3, 1);
    repeat (600) @(negedge loc_clk);
    chk(req_n >= 2, "R6 fast source requests", req_n, 2);
    chk(rq_f[0] == 1 && rq_s[0] == 5, "R6 faster step", rq_s[0], 5);
    chk(rq_t[1] - rq_t[0] >= 256 && rq_t[1] - rq_t[0] <= 300, "R9 holdoff gap", rq_t[1] - rq_t[0], 256);

    do_reset(5, 0);
    repeat (800) @(negedge loc_clk);
    chk(req_n == 1, "R10 no request while pending", req_n, 1);
    chk(rq_f[0] == 0 && (rq_s[0] == -3 || rq_s[0] == -4), "R6 slower step", rq_s[0], -4);
    chk(int'(trim_step) == rq_s[0] && !trim_faster, "R10 held stable", int'(trim_step), rq_s[0]);

    // Phase C: guard band, including coincidence with the averaged decision
    do_reset(5, 1);
    for (int i = 0; i < 40; i++) wr1(i);
    settle;
    chk(req_n == 0 && fill == 40, "R9 guard waits for window", req_n, 0);
    repeat (200) @(negedge loc_clk);
    chk(req_n == 1 && rq_f[0] == 1 && rq_s[0] == 1, "R8 guard high beats average", rq_s[0], 1);
    for (int i = 0; i < 36; i++) rd1;
    repeat (300) @(negedge loc_clk);
    chk(req_n >= 2 && rq_f[1] == 0 && rq_s[1] == -1, "R8 guard low", rq_s[1], -1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule